// File: doc/BRIEF.md
# I2C Master Bus Timing Generator

This block produces the SCL and SDA line waveforms for an I2C controller that acts as bus master. A higher-level controller issues one bus-level command at a time: a start, a repeated start, a single write bit, a single read bit, or a stop. The block then plays out that command's line activity and pulses `done` when the command is finished. Both bus lines are driven through open-drain enables. A 1 on an enable pulls the line low, and a 0 releases it to the pull-up.

All intervals are counted in peripheral clock cycles. A low phase and a high phase are set by a divider and a power-of-two prescaler, with a fixed offset of three cycles. A separate set of dividers and a separate prescaler apply in high-speed mode. The start hold, repeated-start setup, stop setup and bus-free intervals are all whole multiples of these two phase lengths. The delay from SCL falling to the SDA update is a programmable hold setting, clamped so that SDA always changes inside the low phase.

Every command except a stop leaves SCL released when it finishes, so the next command starts by pulling SCL low. SDA may stay pulled low between commands, for example after a start or after a 0 bit. Divider, prescaler, mode and hold inputs must be held stable while `busy` is high.

Top module: `i2c_bus_timer`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `busy`, `done` and `rd_bit` are all 0. `scl_oe` is 0 in every cycle in which `busy` is 0.
- R2: With `hs_mode`=0, define low length TL = `std_ldiv`·2^`std_pre` + 3 and high length TH = `std_hdiv`·2^`std_pre` + 3. In a write or read command, SCL is pulled low at the accept edge and released TL cycles later, and `done` pulses TH cycles after that release.
- R3: With `hs_mode`=1, TL and TH use the same formula with `hs_ldiv`, `hs_hdiv` and `hs_pre`.
- R4: A start command (`cmd_op`=1) pulls SDA low at the accept edge while SCL stays released. `done` follows HM·TH cycles later, and SCL is not pulled during the command. HM is 1 in standard mode, 2 in high-speed mode, and 6 in high-speed mode when `hs_hdiv` is 0.
- R5: A repeated start (`cmd_op`=2) holds SCL low for TL cycles with SDA released, then releases SCL. It pulls SDA low SM·TL cycles after that release and pulses `done` HM·TH cycles after SDA falls. SM is 1 in standard mode, 2 in high-speed mode, and 6 in high-speed mode when `hs_ldiv` is 0.
- R6: In a command that begins by pulling SCL low (`cmd_op` 2 to 5), SDA takes its new value min(`hold_cfg`+3, TL−1) cycles after the accept edge.
- R7: A write (`cmd_op`=3) sets `sda_oe` to the inverse of `cmd_wbit`. A read (`cmd_op`=4) sets `sda_oe` to 0. Either value holds from the SDA update through the end of the high phase.
- R8: During a read, `sda_in` is sampled in the last high-phase cycle and appears on `rd_bit` together with `done`. `rd_bit` changes at no other time.
- R9: A stop (`cmd_op`=5) pulls SDA low at the SDA update and releases SCL TL cycles after accept. It releases SDA TH cycles after the SCL release and pulses `done` TL cycles after the SDA release, with both lines released.
- R10: `done` is high for exactly one cycle, on the same edge that `busy` falls. `busy` rises on the edge that accepts a command. `cmd_valid` is ignored while `busy` is 1 and for op codes 0, 6 and 7.
- R11: While SCL stays released, SDA only falls during a start or repeated start and only rises during a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, accepted when `busy` is 0 |
| cmd_op | input | 3 | 1 start, 2 repeated start, 3 write bit, 4 read bit, 5 stop |
| cmd_wbit | input | 1 | Data bit for a write command |
| hs_mode | input | 1 | 1 selects the high-speed divider set |
| hold_cfg | input | HOLD_W | SDA hold setting, delay = value + 3 cycles |
| std_ldiv | input | DIV_W | Standard low-phase divider |
| std_hdiv | input | DIV_W | Standard high-phase divider |
| std_pre | input | PRE_W | Standard prescaler exponent |
| hs_ldiv | input | DIV_W | High-speed low-phase divider |
| hs_hdiv | input | DIV_W | High-speed high-phase divider |
| hs_pre | input | PRE_W | High-speed prescaler exponent |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| rd_bit | output | 1 | Last bit sampled by a read |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle strobe at command end |

## Verification
A wrong phase counter or repetition count shows up at the ports within one command. An SCL release edge, an SDA edge or the `done` pulse then lands a whole number of cycles off its formula position. A wrong phase state or an outdated command kind would move SDA while SCL is released, or leave `busy` high without a `done` pulse. The bench catches these within one command through edge timing, and the bound checker catches them on the cycle they happen through its SCL/SDA ordering and strobe rules. A stuck read sample shows up as a wrong `rd_bit` on the `done` cycle of the read that exposes it.

// File: rtl/i2c_tim_pkg.sv
package i2c_tim_pkg;
    localparam logic [2:0] OP_START  = 3'd1;
    localparam logic [2:0] OP_RSTART = 3'd2;
    localparam logic [2:0] OP_WRITE  = 3'd3;
    localparam logic [2:0] OP_READ   = 3'd4;
    localparam logic [2:0] OP_STOP   = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOW  = 3'd1,
        ST_HIGH = 3'd2,
        ST_SU   = 3'd3,
        ST_HD   = 3'd4,
        ST_BUF  = 3'd5
    } seq_st_e;

    function automatic logic op_known(input logic [2:0] op);
        return (op >= OP_START) && (op <= OP_STOP);
    endfunction
endpackage

// File: rtl/i2c_phase_calc.sv
module i2c_phase_calc #(
    parameter int DIV_W = 8,
    parameter int PRE_W = 3,
    parameter int LEN_W = DIV_W + (1 << PRE_W)
) (
    input  logic             hs_mode,
    input  logic [DIV_W-1:0] std_ldiv,
    input  logic [DIV_W-1:0] std_hdiv,
    input  logic [PRE_W-1:0] std_pre,
    input  logic [DIV_W-1:0] hs_ldiv,
    input  logic [DIV_W-1:0] hs_hdiv,
    input  logic [PRE_W-1:0] hs_pre,
    output logic [LEN_W-1:0] t_low,
    output logic [LEN_W-1:0] t_high,
    output logic [2:0]       su_rep,
    output logic [2:0]       hd_rep
);
    localparam int PAD_W = LEN_W - DIV_W;

    // Phase length: divider scaled by 2^prescaler plus the fixed 3-cycle offset.
    function automatic logic [LEN_W-1:0] phase_len(input logic [DIV_W-1:0] dv,
                                                   input logic [PRE_W-1:0] pr);
        return ({{PAD_W{1'b0}}, dv} << pr) + LEN_W'(3);
    endfunction

    logic [DIV_W-1:0] sel_l, sel_h;
    logic [PRE_W-1:0] sel_p;

    always_comb begin
        sel_l  = hs_mode ? hs_ldiv : std_ldiv;
        sel_h  = hs_mode ? hs_hdiv : std_hdiv;
        sel_p  = hs_mode ? hs_pre  : std_pre;
        t_low  = phase_len(sel_l, sel_p);
        t_high = phase_len(sel_h, sel_p);
        if (!hs_mode) begin
            su_rep = 3'd1;
            hd_rep = 3'd1;
        end else begin
            su_rep = (hs_ldiv == '0) ? 3'd6 : 3'd2;
            hd_rep = (hs_hdiv == '0) ? 3'd6 : 3'd2;
        end
    end
endmodule

// File: rtl/i2c_line_seq.sv
module i2c_line_seq
    import i2c_tim_pkg::*;
#(
    parameter int HOLD_W = 4,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic              cmd_wbit,
    input  logic [HOLD_W-1:0] hold_cfg,
    input  logic [LEN_W-1:0]  t_low,
    input  logic [LEN_W-1:0]  t_high,
    input  logic [2:0]        su_rep,
    input  logic [2:0]        hd_rep,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              rd_bit,
    output logic              busy,
    output logic              done
);
    typedef struct packed {
        seq_st_e          st;
        logic [LEN_W-1:0] cnt;
        logic [2:0]       rep;
        logic [2:0]       op;
        logic             sda_tgt;
        logic             scl_oe;
        logic             sda_oe;
        logic             rd;
        logic             done;
    } seq_t;

    seq_t q, d;
    logic [LEN_W-1:0] plen, hold_ext, upd_at;
    logic [2:0]       plim;
    logic             cnt_end, last;

    always_comb begin
        // Active phase length and repetition count
        plen = t_low;
        plim = 3'd1;
        case (q.st)
            ST_HIGH: plen = t_high;
            ST_HD: begin
                plen = t_high;
                plim = hd_rep;
            end
            ST_SU: begin
                plen = (q.op == OP_STOP) ? t_high : t_low;
                plim = (q.op == OP_RSTART) ? su_rep : 3'd1;
            end
            default: ;
        endcase
        hold_ext = LEN_W'(hold_cfg) + LEN_W'(3);
        upd_at   = (hold_ext > t_low - LEN_W'(1)) ? t_low - LEN_W'(1) : hold_ext;
        cnt_end  = (q.cnt == plen - LEN_W'(1));
        last     = cnt_end && (q.rep == plim - 3'd1);

        d      = q;
        d.done = 1'b0;
        if (q.st != ST_IDLE) begin
            if (cnt_end) begin
                d.cnt = '0;
                d.rep = last ? 3'd0 : q.rep + 3'd1;
            end else begin
                d.cnt = q.cnt + LEN_W'(1);
            end
        end

        case (q.st)
            ST_IDLE: begin
                if (cmd_valid && op_known(cmd_op)) begin
                    d.op  = cmd_op;
                    d.cnt = '0;
                    d.rep = '0;
                    if (cmd_op == OP_START) begin
                        d.st     = ST_HD;
                        d.sda_oe = 1'b1;
                    end else begin
                        d.st     = ST_LOW;
                        d.scl_oe = 1'b1;
                        case (cmd_op)
                            OP_WRITE: d.sda_tgt = ~cmd_wbit;
                            OP_STOP:  d.sda_tgt = 1'b1;
                            default:  d.sda_tgt = 1'b0;
                        endcase
                    end
                end
            end
            ST_LOW: begin
                if (q.cnt == upd_at - LEN_W'(1)) d.sda_oe = q.sda_tgt;
                if (last) begin
                    d.scl_oe = 1'b0;
                    d.st     = (q.op == OP_WRITE || q.op == OP_READ) ? ST_HIGH : ST_SU;
                end
            end
            ST_HIGH: begin
                if (last) begin
                    if (q.op == OP_READ) d.rd = sda_in;
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            end
            ST_SU: begin
                if (last) begin
                    if (q.op == OP_RSTART) begin
                        d.st     = ST_HD;
                        d.sda_oe = 1'b1;
                    end else begin
                        d.st     = ST_BUF;
                        d.sda_oe = 1'b0;
                    end
                end
            end
            default: begin
                if (last) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign scl_oe = q.scl_oe;
    assign sda_oe = q.sda_oe;
    assign rd_bit = q.rd;
    assign busy   = (q.st != ST_IDLE);
    assign done   = q.done;
endmodule

// File: rtl/i2c_bus_timer.sv
module i2c_bus_timer #(
    parameter int DIV_W  = 8,
    parameter int PRE_W  = 3,
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic              cmd_wbit,
    input  logic              hs_mode,
    input  logic [HOLD_W-1:0] hold_cfg,
    input  logic [DIV_W-1:0]  std_ldiv,
    input  logic [DIV_W-1:0]  std_hdiv,
    input  logic [PRE_W-1:0]  std_pre,
    input  logic [DIV_W-1:0]  hs_ldiv,
    input  logic [DIV_W-1:0]  hs_hdiv,
    input  logic [PRE_W-1:0]  hs_pre,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              rd_bit,
    output logic              busy,
    output logic              done
);
    localparam int LEN_W = DIV_W + (1 << PRE_W);

    logic [LEN_W-1:0] t_low, t_high;
    logic [2:0]       su_rep, hd_rep;

    i2c_phase_calc #(.DIV_W(DIV_W), .PRE_W(PRE_W), .LEN_W(LEN_W)) u_calc (
        .hs_mode (hs_mode),
        .std_ldiv(std_ldiv),
        .std_hdiv(std_hdiv),
        .std_pre (std_pre),
        .hs_ldiv (hs_ldiv),
        .hs_hdiv (hs_hdiv),
        .hs_pre  (hs_pre),
        .t_low   (t_low),
        .t_high  (t_high),
        .su_rep  (su_rep),
        .hd_rep  (hd_rep)
    );

    i2c_line_seq #(.HOLD_W(HOLD_W), .LEN_W(LEN_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .cmd_wbit (cmd_wbit),
        .hold_cfg (hold_cfg),
        .t_low    (t_low),
        .t_high   (t_high),
        .su_rep   (su_rep),
        .hd_rep   (hd_rep),
        .sda_in   (sda_in),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe),
        .rd_bit   (rd_bit),
        .busy     (busy),
        .done     (done)
    );
endmodule

// File: rtl/i2c_bus_timer_chk.sv
module i2c_bus_timer_chk
    import i2c_tim_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       rd_bit,
    input logic       busy,
    input logic       done
);
    logic [2:0] cur_op;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_op <= '0;
        else if (cmd_valid && !busy && op_known(cmd_op)) cur_op <= cmd_op;
    end

    assert_idle_scl_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !scl_oe);

    assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && op_known(cmd_op)) |=> busy);

    assert_done_not_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_busy_fall_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_rd_only_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_bit) |-> done);

    assert_sda_fall_scl_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && $rose(sda_oe)) |-> (cur_op == OP_START || cur_op == OP_RSTART));

    assert_sda_rise_scl_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && $fell(sda_oe)) |-> (cur_op == OP_STOP));

    assert_stop_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cur_op == OP_STOP) |-> (!scl_oe && !sda_oe));
endmodule

bind i2c_bus_timer i2c_bus_timer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .rd_bit   (rd_bit),
    .busy     (busy),
    .done     (done)
);

// File: tb/i2c_bus_timer_tb.sv
module i2c_bus_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic       cmd_wbit = 1'b0;
    logic       hs_mode = 1'b0;
    logic [3:0] hold_cfg = 4'd0;
    logic [7:0] std_ldiv = 8'd0, std_hdiv = 8'd0, hs_ldiv = 8'd0, hs_hdiv = 8'd0;
    logic [2:0] std_pre = 3'd0, hs_pre = 3'd0;
    logic       tb_sda = 1'b1;
    logic       sda_in;
    logic       scl_oe, sda_oe, rd_bit, busy, done;

    assign sda_in = ~sda_oe & tb_sda;

    i2c_bus_timer u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_wbit(cmd_wbit), .hs_mode(hs_mode), .hold_cfg(hold_cfg),
        .std_ldiv(std_ldiv), .std_hdiv(std_hdiv), .std_pre(std_pre),
        .hs_ldiv(hs_ldiv), .hs_hdiv(hs_hdiv), .hs_pre(hs_pre), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .rd_bit(rd_bit), .busy(busy), .done(done)
    );

    always #10 clk = ~clk;

    int checks = 0, errors = 0;
    int tl, th, dly, sm, hm;
    string mtag;
    int ev_k[2];
    logic ev_v[2];
    int n_ev, k_rel, k_done;
    logic sda_at_rel;

    task automatic chk_eq(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic hs, input int l, input int h, input int p, input int hold);
        hs_mode  = hs;
        hold_cfg = 4'(hold);
        if (hs) begin
            hs_ldiv = 8'(l); hs_hdiv = 8'(h); hs_pre = 3'(p);
            sm = (l == 0) ? 6 : 2;
            hm = (h == 0) ? 6 : 2;
            mtag = "R3";
        end else begin
            std_ldiv = 8'(l); std_hdiv = 8'(h); std_pre = 3'(p);
            sm = 1; hm = 1;
            mtag = "R2";
        end
        tl  = l * (1 << p) + 3;
        th  = h * (1 << p) + 3;
        dly = (hold + 3 > tl - 1) ? tl - 1 : hold + 3;
    endtask

    // Issue one command and record edge times relative to the accept edge.
    task automatic run_cmd(input logic [2:0] op, input logic wb);
        logic prev_sda, was_low;
        @(negedge clk);
        prev_sda  = sda_oe;
        cmd_valid = 1'b1; cmd_op = op; cmd_wbit = wb;
        @(negedge clk);
        cmd_valid = 1'b0;
        n_ev = 0; k_rel = -1; k_done = -1; was_low = 1'b0; sda_at_rel = 1'b0;
        chk_eq(int'(busy), 1, "R10 busy after accept");
        for (int k = 0; k < 5000; k++) begin
            if (sda_oe !== prev_sda) begin
                if (n_ev < 2) begin ev_k[n_ev] = k; ev_v[n_ev] = sda_oe; end
                n_ev++;
                prev_sda = sda_oe;
            end
            if (scl_oe) was_low = 1'b1;
            else if (was_low && k_rel < 0) begin k_rel = k; sda_at_rel = sda_oe; end
            if (done) begin k_done = k; break; end
            @(negedge clk);
        end
        @(negedge clk);
        chk_eq(int'(done) + int'(busy), 0, "R10 single done and idle after");
    endtask

    task automatic t_start();
        run_cmd(3'd1, 1'b0);
        chk_eq(n_ev, 1, "R4 sda edges in start");
        chk_eq(ev_k[0] * 2 + int'(ev_v[0]), 1, "R4 sda pulled at accept");
        chk_eq(k_rel, -1, "R4 scl untouched");
        chk_eq(k_done, hm * th, "R4 start hold length");
    endtask

    task automatic t_bit(input logic [2:0] op, input logic wb, input logic expect_edge);
        run_cmd(op, wb);
        chk_eq(k_rel, tl, {mtag, " scl low length"});
        chk_eq(k_done - k_rel, th, {mtag, " scl high length"});
        if (expect_edge) chk_eq(ev_k[0], dly, "R6 sda update delay");
        else chk_eq(n_ev, 0, "R6 no sda edge when value unchanged");
        chk_eq(int'(sda_at_rel), (op == 3'd3) ? int'(!wb) : 0, "R7 sda value in high phase");
        if (op == 3'd4) chk_eq(int'(rd_bit), int'(tb_sda), "R8 read sample");
    endtask

    task automatic t_rstart();
        run_cmd(3'd2, 1'b0);
        chk_eq(ev_k[0] * 2 + int'(ev_v[0]), dly * 2, "R6 rstart sda release delay");
        chk_eq(k_rel, tl, "R5 rstart low length");
        chk_eq(ev_k[1] * 2 + int'(ev_v[1]), (tl + sm * tl) * 2 + 1, "R5 rstart setup");
        chk_eq(k_done, tl + sm * tl + hm * th, "R5 rstart hold");
    endtask

    task automatic t_stop();
        run_cmd(3'd5, 1'b0);
        chk_eq(ev_k[0] * 2 + int'(ev_v[0]), dly * 2 + 1, "R6 stop sda pull delay");
        chk_eq(k_rel, tl, "R9 stop low length");
        chk_eq(ev_k[1] * 2 + int'(ev_v[1]), (tl + th) * 2, "R9 stop setup");
        chk_eq(k_done, tl + th + tl, "R9 bus free");
        chk_eq(int'(scl_oe) + int'(sda_oe), 0, "R9 lines released");
    endtask

    task automatic t_ignore();
        int kd;
        // Unknown op codes in idle
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd6;
        @(negedge clk); cmd_op = 3'd0;
        @(negedge clk); cmd_op = 3'd7;
        @(negedge clk); cmd_valid = 1'b0;
        chk_eq(int'(busy) + int'(scl_oe) + int'(sda_oe), 0, "R10 unknown op ignored");
        // Commands while busy
        cmd_valid = 1'b1; cmd_op = 3'd3; cmd_wbit = 1'b1;
        @(negedge clk);
        cmd_op = 3'd1;
        kd = -1;
        for (int k = 0; k < 2000; k++) begin
            if (k == 4) cmd_valid = 1'b0;
            if (done) begin kd = k; break; end
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        chk_eq(kd, tl + th, "R10 busy command length unchanged");
        repeat (3) @(negedge clk);
        chk_eq(int'(busy) + int'(sda_oe) + int'(scl_oe), 0, "R10 command during busy ignored");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_eq(int'(scl_oe) + int'(sda_oe) + int'(busy) + int'(done) + int'(rd_bit), 0, "R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq(int'(scl_oe) + int'(sda_oe) + int'(busy), 0, "R1 idle after reset");

        set_cfg(1'b0, 4, 3, 1, 2);
        t_start();
        t_bit(3'd3, 1'b1, 1'b1);
        t_bit(3'd3, 1'b0, 1'b1);
        t_rstart();
        tb_sda = 1'b1; t_bit(3'd4, 1'b0, 1'b1);
        tb_sda = 1'b0; t_bit(3'd4, 1'b0, 1'b0);
        tb_sda = 1'b1;
        t_stop();

        set_cfg(1'b0, 2, 5, 0, 13);
        t_start();
        t_bit(3'd3, 1'b1, 1'b1);
        t_stop();

        set_cfg(1'b1, 1, 2, 2, 2);
        t_start();
        t_bit(3'd3, 1'b0, 1'b0);
        t_rstart();
        tb_sda = 1'b1; t_bit(3'd4, 1'b0, 1'b1);
        t_stop();

        set_cfg(1'b1, 0, 0, 2, 2);
        t_start();
        t_rstart();
        t_bit(3'd3, 1'b1, 1'b1);
        t_stop();

        set_cfg(1'b0, 4, 3, 1, 2);
        t_ignore();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule